// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the slave-side serial audio port of a stereo converter. An external bit clock and an external frame clock arrive as plain inputs and are sampled by the fast system clock. The port runs in both directions at once. It serializes a 20-bit left/right pair taken from parallel inputs onto a serial data output, and it assembles a left/right pair from a serial data input into parallel words.

A 2-bit format input selects one of four framings. The two directions can use different justification in the same format. The frame-clock polarity is inverted in the I2S format. The port counts bit clocks in each half-frame and flags a half-frame that is too short for the selected format. It realigns its bit counters on every frame-clock edge, so it recovers from such a half-frame by itself.

Top module: `audio_serial_port`

## Requirements
- R1: Format 2'b00 receives a 16-bit word LSB-justified: the last 16 bits before the frame-clock edge become bits 19:4 of the received word, and bits 3:0 are zero. Format 2'b01 receives a 20-bit word LSB-justified: the last 20 bits before the edge form the word.
- R2: Format 2'b10 receives MSB-justified: the bit sampled in the first bit-clock slot after the frame-clock edge is bit 19, and the following slots carry bits 18 down to 0.
- R3: Format 2'b11 is I2S in both directions. Frame clock low is the left channel and high is the right channel. The MSB occupies the second slot after the edge, and bit b travels in slot 20-b.
- R4: In formats 2'b00, 2'b01 and 2'b10 the serial output carries the 20-bit word MSB-justified, MSB in the first slot after the edge. Frame clock high is the left channel.
- R5: The serial output changes only after a falling bit-clock edge, and the serial input is sampled on rising bit-clock edges.
- R6: With 16 slots per half-frame, the transmitter sends only bits 19:4 and the receiver fills bits 3:0 with zero. This covers format 2'b00 and I2S.
- R7: When a right channel completes, both received words update in the same cycle and rx_valid_o pulses for exactly one cycle. Between pulses the received words hold.
- R8: At the start of each left half, the transmit pair is captured and tx_load_o pulses for one cycle. A change to the transmit inputs later in the frame does not alter the frame being sent.
- R9: frame_err_o pulses for one cycle at a frame-clock edge when the half-frame that just ended had fewer bit clocks than the format allows. The minimum is 16 in format 2'b00 and 20 in formats 2'b01 and 2'b10. Format 2'b11 accepts exactly 16 or at least 20.
- R10: After short half-frames, the following legal frames are transferred correctly in both directions and raise no further error.
- R11: During and after reset the serial output, both received words, rx_valid_o, tx_load_o and frame_err_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing format select |
| sclk_i | input | 1 | External bit clock |
| lrck_i | input | 1 | External frame clock |
| sdti_i | input | 1 | Serial data in (toward the DAC) |
| sdto_o | output | 1 | Serial data out (from the ADC) |
| tx_left_i | input | 20 | Left sample to transmit |
| tx_right_i | input | 20 | Right sample to transmit |
| tx_load_o | output | 1 | Pulse when the transmit pair is captured |
| rx_left_o | output | 20 | Received left sample |
| rx_right_o | output | 20 | Received right sample |
| rx_valid_o | output | 1 | Pulse when a received pair is presented |
| frame_err_o | output | 1 | Pulse on a half-frame that is too short |

## Verification
The bench targets the I2S half-frame of 16 slots. There, the least significant transmitted bit spills into the first slot of the next channel. A design that stops at the frame-clock edge loses bit 4 on receive. A design that starts the new word at once sends the wrong bit in that slot. It also runs each LSB-justified format with more slots than bits, where a receiver counting from the edge would latch leading zeros. A mid-frame change of the transmit inputs catches a transmitter that reads its inputs live. The runs of short half-frames followed by legal frames catch two faults. A monitor with the wrong limit per format either stays silent or fires on legal traffic. A port that fails to realign on the next edge stays misaligned.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {
    FMT_L16 = 2'b00,
    FMT_L20 = 2'b01,
    FMT_M20 = 2'b10,
    FMT_I2S = 2'b11
  } asp_fmt_e;

  function automatic logic fmt_is_i2s(asp_fmt_e f);
    return f == FMT_I2S;
  endfunction

  function automatic logic fmt_rx_lsb(asp_fmt_e f);
    return (f == FMT_L16) || (f == FMT_L20);
  endfunction
endpackage

// File: rtl/asp_edge_sync.sv
module asp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic sdti_i,
  output logic rise_o,
  output logic fall_o,
  output logic lrck_o,
  output logic sdti_o
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b100;  // bit clock idles high

  logic [NSIG-1:0] stg_q [STAGES];
  logic            sclk_q;
  logic            sclk_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE;
      sclk_q <= 1'b1;
    end else begin
      stg_q[0] <= {sclk_i, lrck_i, sdti_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sclk_q <= sclk_s;
    end
  end

  assign sclk_s = stg_q[STAGES-1][2];
  assign lrck_o = stg_q[STAGES-1][1];
  assign sdti_o = stg_q[STAGES-1][0];
  assign rise_o = sclk_s & ~sclk_q;
  assign fall_o = ~sclk_s & sclk_q;

  AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);  // R5
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  asp_fmt_e          fmt_i,
  input  logic              fall_i,
  input  logic              lrck_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              sdto_o,
  output logic              load_o
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam logic [NB_W-1:0] FULL = NB_W'(DATA_W);
  localparam logic [NB_W-1:0] ONE  = NB_W'(1);

  logic              lr_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rshadow_q;
  logic [NB_W-1:0]   rem_q;
  logic              i2s;
  logic              new_half;
  logic              is_left;
  logic              more;
  logic [DATA_W-1:0] word;

  assign i2s      = fmt_is_i2s(fmt_i);
  assign new_half = lrck_i != lr_q;
  assign is_left  = lrck_i ^ i2s;
  assign word     = is_left ? left_i : rshadow_q;
  assign more     = rem_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q      <= 1'b0;
      sh_q      <= '0;
      rshadow_q <= '0;
      rem_q     <= '0;
      sdto_o    <= 1'b0;
      load_o    <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (fall_i) begin
        if (new_half) begin
          lr_q <= lrck_i;
          if (is_left) begin
            rshadow_q <= right_i;
            load_o    <= 1'b1;
          end
          if (i2s) begin
            // one more slot of the previous word, then the new word
            sdto_o <= more & sh_q[DATA_W-1];
            sh_q   <= word;
            rem_q  <= FULL;
          end else begin
            sdto_o <= word[DATA_W-1];
            sh_q   <= word << 1;
            rem_q  <= FULL - ONE;
          end
        end else begin
          sdto_o <= more & sh_q[DATA_W-1];
          sh_q   <= sh_q << 1;
          if (more) rem_q <= rem_q - ONE;
        end
      end
    end
  end

  AST_TX_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdto_o));  // R5
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);  // R8
  AST_LOAD_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(fall_i));  // R8
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int DATA_W  = 20,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  asp_fmt_e          fmt_i,
  input  logic              rise_i,
  input  logic              lrck_i,
  input  logic              sdti_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam logic [NB_W-1:0] FULL = NB_W'(DATA_W);
  localparam logic [NB_W-1:0] ONE  = NB_W'(1);
  localparam int PAD = DATA_W - SHORT_W;

  logic              lr_q;
  logic              armed_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] lhold_q;
  logic [NB_W-1:0]   nbits_q;
  logic              i2s;
  logic              lsb;
  logic              new_half;
  logic              old_left;
  logic [DATA_W-1:0] shifted;
  logic [NB_W-1:0]   nbits_inc;
  logic [DATA_W-1:0] word;

  assign i2s       = fmt_is_i2s(fmt_i);
  assign lsb       = fmt_rx_lsb(fmt_i);
  assign new_half  = lrck_i != lr_q;
  assign old_left  = lr_q ^ i2s;
  assign shifted   = {sh_q[DATA_W-2:0], sdti_i};
  assign nbits_inc = nbits_q + ONE;

  always_comb begin
    unique case (fmt_i)
      FMT_L16: word = sh_q << PAD;
      FMT_L20: word = sh_q;
      FMT_M20: word = sh_q << (FULL - nbits_q);
      default: word = (nbits_q < FULL) ? (shifted << (FULL - nbits_inc)) : sh_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q    <= 1'b0;
      armed_q <= 1'b0;
      sh_q    <= '0;
      lhold_q <= '0;
      nbits_q <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        if (new_half) begin
          lr_q    <= lrck_i;
          armed_q <= 1'b1;
          if (armed_q) begin
            if (old_left) begin
              lhold_q <= word;
            end else begin
              left_o  <= lhold_q;
              right_o <= word;
              valid_o <= 1'b1;
            end
          end
          if (i2s) begin
            sh_q    <= '0;
            nbits_q <= '0;
          end else begin
            sh_q    <= {{(DATA_W-1){1'b0}}, sdti_i};
            nbits_q <= ONE;
          end
        end else if (lsb || nbits_q < FULL) begin
          sh_q <= shifted;
          if (nbits_q < FULL) nbits_q <= nbits_inc;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R7
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));  // R7
  AST_VALID_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));  // R5
endmodule

// File: rtl/asp_frame_mon.sv
module asp_frame_mon
  import asp_pkg::*;
#(
  parameter int DATA_W  = 20,
  parameter int SHORT_W = 16,
  parameter int CNT_W   = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  asp_fmt_e fmt_i,
  input  logic     rise_i,
  input  logic     lrck_i,
  output logic     err_o
);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_W);
  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             lr_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             len_ok;

  always_comb begin
    unique case (fmt_i)
      FMT_L16: len_ok = cnt_q >= SHORT_C;
      FMT_I2S: len_ok = (cnt_q == SHORT_C) || (cnt_q >= LONG_C);
      default: len_ok = cnt_q >= LONG_C;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (rise_i) begin
        if (lrck_i != lr_q) begin
          lr_q    <= lrck_i;
          armed_q <= 1'b1;
          err_o   <= armed_q & ~len_ok;
          cnt_q   <= ONE;
        end else if (cnt_q != '1) begin
          cnt_q <= cnt_q + ONE;
        end
      end
    end
  end

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);  // R9
  AST_ERR_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rise_i));  // R9
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int DATA_W      = 20,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              sdti_i,
  output logic              sdto_o,
  input  logic [DATA_W-1:0] tx_left_i,
  input  logic [DATA_W-1:0] tx_right_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_left_o,
  output logic [DATA_W-1:0] rx_right_o,
  output logic              rx_valid_o,
  output logic              frame_err_o
);
  asp_fmt_e fmt;
  logic     rise;
  logic     fall;
  logic     lrck_s;
  logic     sdti_s;

  assign fmt = asp_fmt_e'(fmt_i);

  asp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .lrck_i (lrck_i),
    .sdti_i (sdti_i),
    .rise_o (rise),
    .fall_o (fall),
    .lrck_o (lrck_s),
    .sdti_o (sdti_s)
  );

  asp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt),
    .fall_i  (fall),
    .lrck_i  (lrck_s),
    .left_i  (tx_left_i),
    .right_i (tx_right_i),
    .sdto_o  (sdto_o),
    .load_o  (tx_load_o)
  );

  asp_rx #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fmt_i   (fmt),
    .rise_i  (rise),
    .lrck_i  (lrck_s),
    .sdti_i  (sdti_s),
    .left_o  (rx_left_o),
    .right_o (rx_right_o),
    .valid_o (rx_valid_o)
  );

  asp_frame_mon #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fmt_i  (fmt),
    .rise_i (rise),
    .lrck_i (lrck_s),
    .err_o  (frame_err_o)
  );

  AST_NO_LOAD_IN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !tx_load_o);  // R5
endmodule

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;
  localparam int H = 8;  // system clocks per bit-clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        sclk = 1'b1;
  logic        lrck = 1'b0;
  logic        sdti = 1'b0;
  logic        sdto;
  logic [19:0] tx_left = '0;
  logic [19:0] tx_right = '0;
  logic        tx_load;
  logic [19:0] rx_left;
  logic [19:0] rx_right;
  logic        rx_valid;
  logic        frame_err;

  int n_checks = 0;
  int n_fail = 0;
  int val_cnt = 0;
  int load_cnt = 0;
  int err_total = 0;
  int err_late = 0;
  bit done = 1'b0;
  logic s [0:256];

  always #4 clk = ~clk;

  audio_serial_port uut (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .sclk_i(sclk), .lrck_i(lrck),
    .sdti_i(sdti), .sdto_o(sdto), .tx_left_i(tx_left), .tx_right_i(tx_right),
    .tx_load_o(tx_load), .rx_left_o(rx_left), .rx_right_o(rx_right),
    .rx_valid_o(rx_valid), .frame_err_o(frame_err)
  );

  always @(posedge clk) begin
    if (rx_valid) val_cnt++;
    if (tx_load) load_cnt++;
    if (frame_err) begin err_total++; err_late++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input bit cond, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic drive_bit(int mode, int n, int k, logic [19:0] cur, logic [19:0] prev);
    case (mode)
      0: return (k >= n - 16) ? cur[15 - (k - (n - 16))] : 1'b0;
      1: return (k >= n - 20) ? cur[19 - (k - (n - 20))] : 1'b0;
      2: return (k < 20) ? cur[19 - k] : 1'b0;
      default: begin
        if (k == 0) return (n <= 20) ? prev[20 - n] : 1'b0;
        return (k <= 20) ? cur[20 - k] : 1'b0;
      end
    endcase
  endfunction

  function automatic logic [19:0] exp_rx(int mode, int n, logic [19:0] w);
    if (mode == 0) return {w[15:0], 4'h0};
    if (mode == 3 && n < 20) return {w[19:4], 4'h0};
    return w;
  endfunction

  function automatic logic [19:0] exp_tx(int n, logic [19:0] w);
    return (n >= 20) ? w : {w[19:4], 4'h0};
  endfunction

  function automatic logic [19:0] decode(int mode, int n, int base);
    logic [19:0] d = '0;
    int lim;
    if (mode < 3) begin
      lim = (n < 20) ? n : 20;
      for (int k = 0; k < lim; k++) d[19 - k] = s[base + k];
    end else begin
      lim = (n - 1 < 20) ? n - 1 : 20;
      for (int k = 1; k <= lim; k++) d[20 - k] = s[base + k];
      if (n <= 20) d[20 - n] = s[base + n];
    end
    return d;
  endfunction

  task automatic slot(input logic lr, input logic b, output logic smp);
    @(negedge clk);
    sclk = 1'b0; lrck = lr; sdti = b;
    repeat (H) @(negedge clk);
    smp = sdto;
    sclk = 1'b1;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic do_reset(input int mode, input logic idle_lr);
    @(negedge clk);
    rst_n = 1'b0; fmt = 2'(mode); sclk = 1'b1; lrck = idle_lr; sdti = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    val_cnt = 0; load_cnt = 0; err_total = 0; err_late = 0;
  endtask

  // fa frames of na slots per half, then fb frames of nb slots per half
  task automatic play(input string tag, input int mode, input int na, input int fa,
                      input int nb, input int fb, input logic [19:0] rl, input logic [19:0] rr,
                      input logic [19:0] tl, input logic [19:0] tr);
    logic left_lvl = (mode == 3) ? 1'b0 : 1'b1;
    logic smp;
    int pre = (fa > 0) ? na : nb;
    do_reset(mode, ~left_lvl);
    tx_left = tl; tx_right = tr;
    for (int k = 0; k < pre; k++) slot(~left_lvl, 1'b0, smp);
    for (int f = 0; f < fa + fb; f++) begin
      int n = (f < fa) ? na : nb;
      bit last = (f == fa + fb - 1);
      if (f == fa + 1) err_late = 0;
      for (int ch = 0; ch < 2; ch++) begin
        logic [19:0] cur = ch ? rr : rl;
        logic [19:0] prv = ch ? rl : rr;
        logic lv = ch ? ~left_lvl : left_lvl;
        for (int k = 0; k < n; k++) begin
          slot(lv, drive_bit(mode, n, k, cur, prv), smp);
          if (last) s[ch * n + k] = smp;
          if (last && ch == 0 && k == n / 2) begin
            tx_left = ~tl; tx_right = ~tr;  // must not reach this frame (R8)
          end
        end
      end
    end
    slot(left_lvl, drive_bit(mode, nb, 0, rl, rr), smp);
    s[2 * nb] = smp;
    repeat (2 * H) @(negedge clk);
    chk({tag, " R1 R2 R3 R6 rx left"}, 32'(rx_left), 32'(exp_rx(mode, nb, rl)));
    chk({tag, " R1 R2 R3 R6 rx right"}, 32'(rx_right), 32'(exp_rx(mode, nb, rr)));
    chk({tag, " R4 R3 R6 R8 tx left"}, 32'(decode(mode, nb, 0)), 32'(exp_tx(nb, tl)));
    chk({tag, " R4 R3 R6 R8 tx right"}, 32'(decode(mode, nb, nb)), 32'(exp_tx(nb, tr)));
    chk_true({tag, " R7 valid count"}, val_cnt >= fb, val_cnt, fb);
    chk_true({tag, " R8 load count"}, load_cnt >= fa + fb, load_cnt, fa + fb);
    if (fa == 0) begin
      chk_true({tag, " R9 no error on legal frames"}, err_total == 0, err_total, 0);
    end else begin
      chk_true({tag, " R9 short half flagged"}, err_total >= 1, err_total, 1);
      chk_true({tag, " R10 no error after resync"}, err_late == 0, err_late, 0);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 sdto in reset", 32'(sdto), 32'(0));
    chk("R11 rx_left in reset", 32'(rx_left), 32'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 rx_right after reset", 32'(rx_right), 32'(0));
    chk("R11 pulses after reset", 32'({rx_valid, tx_load, frame_err}), 32'(0));
  endtask

  initial begin
    test_reset();
    play("m0 32fs", 0, 16, 0, 16, 3, 20'hA5C3E, 20'h3B791, 20'hC6A59, 20'h1E2D7);
    play("m0 64fs", 0, 32, 0, 32, 3, 20'h5A3C1, 20'hE7104, 20'h93F0A, 20'h4B5E2);
    play("m1 64fs", 1, 32, 0, 32, 3, 20'hA5C3E, 20'h3B791, 20'h0F0F3, 20'hF1234);
    play("m2 40fs", 2, 20, 0, 20, 3, 20'h86421, 20'h7BCDE, 20'h55AA9, 20'hAA556);
    play("m2 64fs", 2, 32, 0, 32, 3, 20'hA5C3E, 20'h3B791, 20'hC6A59, 20'h1E2D7);
    play("m3 64fs", 3, 32, 0, 32, 3, 20'hA5C3E, 20'h3B791, 20'hC6A59, 20'h1E2D7);
    play("m3 32fs", 3, 16, 0, 16, 3, 20'hA5C3E, 20'h3B7F1, 20'hC6A5F, 20'h1E2D7);
    play("m3 40fs", 3, 20, 0, 20, 3, 20'h86421, 20'h7BCDE, 20'h55AA9, 20'hAA556);
    play("m1 short", 1, 16, 2, 32, 3, 20'h12345, 20'hFEDCB, 20'h9A5C3, 20'h6B1E4);
    play("m3 36fs", 3, 18, 2, 16, 3, 20'hA5C3E, 20'h3B7F1, 20'hC6A5F, 20'h1E2D7);
    play("m0 24fs", 0, 12, 2, 32, 3, 20'h5A3C1, 20'hE7104, 20'h93F0A, 20'h4B5E2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule